// File: doc/BRIEF.md
# Internal Scratchpad RAM Access Unit

This block holds the 256-byte internal data memory of an 8-bit microcontroller core and decides, for every request, where the access lands. A request carries an address and four qualifiers: read or write, direct or indirect mode, byte or single-bit access, and whether the address is a register operand. Register operands are relocated into one of four 8-byte register banks chosen by a two-bit bank select. Bit operations reach a 16-byte window starting at byte 20h. Bit writes are read-modify-write updates that finish in a single cycle.

The upper half of the byte space, 80h to FFh, is shared by two resources. Indirect accesses reach RAM there. Direct accesses, and bit addresses of 80h and above, go out on a special-function-register port in the same cycle and leave RAM alone. RAM reads return one cycle after the request.

Top module: `iram_access_unit`

## Requirements
- R1: While `rst_n` is low, requests are ignored: `sfr_valid` stays 0 and `rd_valid` is 0 on the cycle after reset is released.
- R2: When `req_reg` is 1, the access is a byte access to RAM byte `bank_sel*8 + req_addr[2:0]`. This holds in either mode, and `req_addr[7:3]` and `req_bit` are ignored.
- R3: When `req_bit` is 1, `req_reg` is 0 and `req_addr` is below 80h, the target is bit `req_addr[2:0]` of byte `20h + req_addr[6:3]`. A bit read returns that bit in `rd_data[0]`, with `rd_data[7:1]` equal to 0.
- R4: A bit write stores `req_wdata[0]` into the addressed bit in one cycle and leaves the other seven bits of that byte unchanged.
- R5: A byte access (`req_bit`=0, `req_reg`=0) to 00h–7Fh reaches RAM in both direct and indirect mode.
- R6: An indirect byte access (`req_indirect`=1) to 80h–FFh reaches RAM.
- R7: A direct byte access to 80h–FFh raises `sfr_valid` in the same cycle. It forwards address, write flag and write data, with `sfr_bit`=0, and neither reads nor changes RAM.
- R8: A bit access with `req_addr` of 80h or above raises `sfr_valid` in the same cycle, with `sfr_bit`=1 and `sfr_addr` equal to `req_addr`, and does not touch RAM.
- R9: A RAM read raises `rd_valid` for exactly the following cycle, with the data in `rd_data`. Writes and forwarded accesses raise no `rd_valid`.
- R10: A read issued on the cycle right after a write to the same byte returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = indirect mode, 0 = direct mode |
| req_bit | input | 1 | 1 = single-bit access, address is a bit address |
| req_reg | input | 1 | 1 = register operand, bank-relative |
| bank_sel | input | 2 | Register bank select |
| req_addr | input | 8 | Byte, bit or register address |
| req_wdata | input | 8 | Write data; bit writes use bit 0 |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 8 | Read data |
| sfr_valid | output | 1 | Access forwarded to the SFR port |
| sfr_write | output | 1 | Forwarded write flag |
| sfr_bit | output | 1 | Forwarded access is a bit access |
| sfr_addr | output | 8 | Forwarded address, unchanged |
| sfr_wdata | output | 8 | Forwarded write data |

## Verification
The assertions assume at most one request per cycle, with qualifiers and address free of unknowns while `req_valid` is high. They also assume every byte has been written before it is read, so that reads never return undefined contents. The bench drives exactly one request per clock from a single task. Before any read, it fills all 256 bytes with zero through indirect byte writes. Its randomised phase draws only legal combinations of mode, bank and address, and fixes their precedence: register operands first, then bit accesses.

// File: rtl/iram_pkg.sv
// Package: shared types for the scratchpad RAM access unit.
// Assumes: one request per cycle; the route is decided combinationally.
package iram_pkg;
    // Destination of the current request.
    typedef enum logic [1:0] {
        RT_NONE     = 2'd0,
        RT_RAM_BYTE = 2'd1,
        RT_RAM_BIT  = 2'd2,
        RT_SFR      = 2'd3
    } route_e;
endpackage

// File: rtl/iram_addr_decode.sv
// Module: iram_addr_decode
// Classifies a request and computes its physical RAM byte and bit position.
// Precedence: register operand, then bit access, then byte access.
// Assumes: the address MSB splits the lower RAM from the shared upper half.
module iram_addr_decode
    import iram_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 8,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_BYTES = 8,
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  logic                         valid,
    input  logic                         indirect,
    input  logic                         bitop,
    input  logic                         regop,
    input  logic [$clog2(NUM_BANKS)-1:0] bank,
    input  logic [AW-1:0]                addr,
    output route_e                       route,
    output logic [AW-1:0]                ram_addr,
    output logic [$clog2(DW)-1:0]        bit_pos
);
    localparam int RW  = $clog2(BANK_BYTES);
    localparam int BPW = $clog2(DW);

    logic upper;
    assign upper = addr[AW-1];

    // Route selection and physical address generation.
    always_comb begin
        route    = RT_NONE;
        ram_addr = addr;
        bit_pos  = addr[BPW-1:0];
        if (valid) begin
            if (regop) begin
                route    = RT_RAM_BYTE;
                ram_addr = AW'({bank, addr[RW-1:0]});
            end else if (bitop) begin
                if (upper) begin
                    route = RT_SFR;
                end else begin
                    route    = RT_RAM_BIT;
                    ram_addr = BIT_BASE + AW'(addr[AW-2:BPW]);
                end
            end else if (upper && !indirect) begin
                route = RT_SFR;
            end else begin
                route = RT_RAM_BYTE;
            end
        end
    end
endmodule

// File: rtl/iram_array.sv
// Module: iram_array
// Flop-based byte array with byte write, single-cycle bit read-modify-write,
// and a registered read port (byte or zero-extended bit).
// Assumes: the caller never asserts a write and a read in the same cycle.
module iram_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_byte,
    input  logic                  we_bit,
    input  logic                  re,
    input  logic                  rd_bit,
    input  logic [AW-1:0]         addr,
    input  logic [$clog2(DW)-1:0] bit_pos,
    input  logic [DW-1:0]         wdata,
    output logic                  rd_valid,
    output logic [DW-1:0]         rd_data
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] cur_word;
    logic [DW-1:0] bit_mask;
    logic [DW-1:0] merged;

    assign cur_word = mem[addr];
    assign bit_mask = DW'(1) << bit_pos;
    assign merged   = wdata[0] ? (cur_word | bit_mask) : (cur_word & ~bit_mask);

    // Storage update: whole byte, or one bit merged into the current byte.
    always_ff @(posedge clk) begin
        if (we_byte) begin
            mem[addr] <= wdata;
        end else if (we_bit) begin
            mem[addr] <= merged;
        end
    end

    // Registered read port with a one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= re;
            if (re) begin
                rd_data <= rd_bit ? {{(DW-1){1'b0}}, cur_word[bit_pos]} : cur_word;
            end
        end
    end

    AST_BIT_KEEPS_NEIGHBOURS: assert property (@(posedge clk) disable iff (!rst_n)
        we_bit |=> ((mem[$past(addr)] ^ $past(cur_word)) & ~$past(bit_mask)) == '0); // R4
    AST_BIT_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        we_bit |=> mem[$past(addr)][$past(bit_pos)] == $past(wdata[0])); // R4
    AST_BYTE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_byte |=> mem[$past(addr)] == $past(wdata)); // R10
endmodule

// File: rtl/iram_access_unit.sv
// Module: iram_access_unit (top)
// Internal scratchpad RAM with bank decoding, bit addressing and
// forwarding of upper-half direct and upper bit accesses to an SFR port.
// Assumes: one request per cycle, request fields known while req_valid is 1.
module iram_access_unit
    import iram_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 8,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_BYTES = 8,
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_indirect,
    input  logic                         req_bit,
    input  logic                         req_reg,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_sel,
    input  logic [AW-1:0]                req_addr,
    input  logic [DW-1:0]                req_wdata,
    output logic                         rd_valid,
    output logic [DW-1:0]                rd_data,
    output logic                         sfr_valid,
    output logic                         sfr_write,
    output logic                         sfr_bit,
    output logic [AW-1:0]                sfr_addr,
    output logic [DW-1:0]                sfr_wdata
);
    localparam int BPW        = $clog2(DW);
    localparam int BANK_TOTAL = NUM_BANKS * BANK_BYTES;
    localparam int BIT_BYTES  = 2 ** (AW - 1 - BPW);

    logic            live;
    route_e          route;
    logic [AW-1:0]   ram_addr;
    logic [BPW-1:0]  bit_pos;
    logic            to_ram;
    logic            we_byte;
    logic            we_bit;
    logic            re;

    // Requests are ignored while reset is held.
    assign live = req_valid && rst_n;

    iram_addr_decode #(
        .AW(AW), .DW(DW), .NUM_BANKS(NUM_BANKS),
        .BANK_BYTES(BANK_BYTES), .BIT_BASE(BIT_BASE)
    ) i_decode (
        .valid    (live),
        .indirect (req_indirect),
        .bitop    (req_bit),
        .regop    (req_reg),
        .bank     (bank_sel),
        .addr     (req_addr),
        .route    (route),
        .ram_addr (ram_addr),
        .bit_pos  (bit_pos)
    );

    // Array strobes derived from the route.
    always_comb begin
        to_ram  = (route == RT_RAM_BYTE) || (route == RT_RAM_BIT);
        we_byte = (route == RT_RAM_BYTE) && req_write;
        we_bit  = (route == RT_RAM_BIT) && req_write;
        re      = to_ram && !req_write;
    end

    iram_array #(.AW(AW), .DW(DW)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_byte  (we_byte),
        .we_bit   (we_bit),
        .re       (re),
        .rd_bit   (route == RT_RAM_BIT),
        .addr     (ram_addr),
        .bit_pos  (bit_pos),
        .wdata    (req_wdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // SFR port: same-cycle forwarding, address passed through unchanged.
    always_comb begin
        sfr_valid = (route == RT_SFR);
        sfr_write = req_write;
        sfr_bit   = req_bit;
        sfr_addr  = req_addr;
        sfr_wdata = req_wdata;
    end

    AST_REG_IN_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_reg) |-> (int'(ram_addr) < BANK_TOTAL) && !sfr_valid); // R2
    AST_BIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_bit && !req_reg && !req_addr[AW-1]) |->
        (ram_addr >= BIT_BASE) && (int'(ram_addr) < int'(BIT_BASE) + BIT_BYTES)); // R3
    AST_LOWER_NEVER_SFR: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_valid |-> sfr_addr[AW-1]); // R5
    AST_INDIRECT_TO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_indirect && !req_bit) |-> !sfr_valid); // R6
    AST_SFR_NO_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_valid |=> !rd_valid); // R7
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !sfr_valid) |=> rd_valid); // R9
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_write) |=> !rd_valid); // R9
endmodule

// File: tb/test_iram_access_unit.sv
// Scoreboard bench: the driver pushes expected read data, the monitor pops it.
module test_iram_access_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
    logic       req_bit = 1'b0, req_reg = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
    logic       rd_valid, sfr_valid, sfr_write, sfr_bit;
    logic [7:0] rd_data, sfr_addr, sfr_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iram_access_unit i_iram_access_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_indirect(req_indirect), .req_bit(req_bit), .req_reg(req_reg),
        .bank_sel(bank_sel), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .sfr_valid(sfr_valid),
        .sfr_write(sfr_write), .sfr_bit(sfr_bit), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Driver: one request per clock, expected results computed from the requirements.
    task automatic do_op(input bit wr, input bit ind, input bit bop, input bit rop,
                         input logic [1:0] bank, input logic [7:0] addr,
                         input logic [7:0] wd, input string tag);
        bit         sfr_exp;
        logic [7:0] ra;
        int         pos;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_indirect = ind; req_bit = bop;
        req_reg = rop; bank_sel = bank; req_addr = addr; req_wdata = wd;
        #1;
        sfr_exp = 1'b0; ra = addr; pos = int'(addr[2:0]);
        if (rop)                  ra = {3'b000, bank, addr[2:0]};
        else if (bop && addr[7])  sfr_exp = 1'b1;
        else if (bop)             ra = 8'h20 + {4'h0, addr[6:3]};
        else if (addr[7] && !ind) sfr_exp = 1'b1;
        if (sfr_exp) begin
            check(sfr_valid == 1'b1, {tag, " sfr_valid"}, {7'd0, sfr_valid}, 8'h01);
            check(sfr_addr == addr, {tag, " sfr_addr"}, sfr_addr, addr);
            check(sfr_bit == bop && sfr_write == wr, {tag, " sfr_bit/write"},
                  {6'd0, sfr_bit, sfr_write}, {6'd0, bop, wr});
            if (wr) check(sfr_wdata == wd, {tag, " sfr_wdata"}, sfr_wdata, wd);
        end else begin
            check(sfr_valid == 1'b0, {tag, " no sfr"}, {7'd0, sfr_valid}, 8'h00);
            if (wr) begin
                if (bop && !rop) model[ra][pos] = wd[0];
                else             model[ra] = wd;
            end else begin
                exp_q.push_back((bop && !rop) ? {7'd0, model[ra][pos]} : model[ra]);
                tag_q.push_back(tag);
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_bit = 1'b0; req_reg = 1'b0;
    endtask

    // Monitor: compares each returned read against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rd_valid", rd_data, 8'h00);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", 8'h00, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        // R1: request held during reset is ignored.
        @(negedge clk);
        req_valid = 1'b1; req_indirect = 1'b0; req_addr = 8'h90;
        #1 check(sfr_valid == 1'b0, "R1 sfr_valid in reset", {7'd0, sfr_valid}, 8'h00);
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);

        // Zero-fill through indirect byte writes.
        for (int a = 0; a < 256; a++) do_op(1, 1, 0, 0, 2'd0, 8'(a), 8'h00, "fill");

        // R5 / R6: byte accesses in both halves.
        do_op(1, 0, 0, 0, 2'd0, 8'h45, 8'hA5, "R5 direct write low");
        do_op(0, 1, 0, 0, 2'd0, 8'h45, 8'h00, "R5 indirect read low");
        do_op(1, 1, 0, 0, 2'd0, 8'hC3, 8'h3C, "R6 indirect write high");
        do_op(0, 1, 0, 0, 2'd0, 8'hC3, 8'h00, "R6 indirect read high");
        // R7: direct upper goes to SFR; RAM byte keeps 3C.
        do_op(1, 0, 0, 0, 2'd0, 8'hC3, 8'hFF, "R7 direct write high");
        do_op(0, 0, 0, 0, 2'd0, 8'hC3, 8'h00, "R7 direct read high");
        do_op(0, 1, 0, 0, 2'd0, 8'hC3, 8'h00, "R7 ram untouched");
        // R2: register operands in each bank, read back by plain address.
        for (int b = 0; b < 4; b++) begin
            do_op(1, 0, 0, 1, 2'(b), 8'hF8 | 8'(b + 3), 8'(8'h10 * b + 1), "R2 reg write");
            do_op(0, 0, 0, 0, 2'd0, 8'(b * 8 + b + 3), 8'h00, "R2 reg readback");
            do_op(0, 1, 0, 1, 2'(b), 8'(b + 3), 8'h00, "R2 reg read");
        end
        // R3 / R4: bit set and clear, neighbours checked through byte reads.
        do_op(1, 0, 0, 0, 2'd0, 8'h2F, 8'h5A, "R4 seed byte");
        do_op(1, 0, 1, 0, 2'd0, 8'h7F, 8'h01, "R4 set bit 7F");
        do_op(0, 0, 0, 0, 2'd0, 8'h2F, 8'h00, "R4 neighbours after set");
        do_op(1, 0, 1, 0, 2'd0, 8'h79, 8'h00, "R4 clear bit 79");
        do_op(0, 0, 0, 0, 2'd0, 8'h2F, 8'h00, "R4 neighbours after clear");
        do_op(0, 0, 1, 0, 2'd0, 8'h7E, 8'h00, "R3 bit read one");
        do_op(0, 0, 1, 0, 2'd0, 8'h79, 8'h00, "R3 bit read zero");
        do_op(1, 0, 1, 0, 2'd0, 8'h00, 8'hFF, "R3 set bit 00");
        do_op(0, 0, 0, 0, 2'd0, 8'h20, 8'h00, "R3 byte 20 holds bit 0");
        // R8: upper bit address forwarded; RAM at 2x and upper bytes untouched.
        do_op(1, 0, 1, 0, 2'd0, 8'h83, 8'h01, "R8 bit write upper");
        do_op(0, 1, 1, 0, 2'd0, 8'hE0, 8'h00, "R8 bit read upper");
        do_op(0, 1, 0, 0, 2'd0, 8'h83, 8'h00, "R8 ram untouched");
        // R10: back-to-back write then read of the same byte.
        do_op(1, 1, 0, 0, 2'd0, 8'hF0, 8'h77, "R10 write");
        do_op(0, 1, 0, 0, 2'd0, 8'hF0, 8'h00, "R10 read next cycle");
        idle();
        // R9: an idle cycle must not raise rd_valid.
        @(negedge clk);
        check(rd_valid == 1'b0, "R9 idle no rd_valid", {7'd0, rd_valid}, 8'h00);

        // Randomised legal mix.
        for (int i = 0; i < 600; i++) begin
            do_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
                  2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                  8'($urandom_range(0, 255)), "R9 random mix");
        end
        idle();
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads returned", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule